// File: doc/BRIEF.md
# Debug Communication Mailbox

This block passes 32-bit words both ways between a processor bus port and a debug-emulator port. The processor deposits a word in an outbound data register for the emulator. The emulator deposits a word in an inbound data register for the processor. A shared status register tells each side whether unread data is waiting. It also records two sticky event flags: one for "the emulator wrote a word" and one for "the emulator consumed the processor's word". A control register lets software choose which of those events drive a single registered interrupt line.

Each side has its own small register port: a 2-bit address, write enable, read enable, write data and read data. Read data is combinational. The register map is the same from both sides:

| Address | Register |
|---|---|
| 0 | outbound data |
| 1 | inbound data |
| 2 | status |
| 3 | control |

A debug-mode input makes every read free of side effects, so a debugger can inspect the mailbox without changing it. Flow control is left to software: each side polls the status register before it writes or reads.

The status register has four defined bits:

| Bit | Meaning |
|---|---|
| 0 | outbound-dirty |
| 1 | inbound-event |
| 2 | consumed-event |
| 3 | inbound-dirty |

Top module: `dbg_mailbox`

## Requirements
- R1: After reset, both data registers, the status register and the control register read as 0, and the interrupt output is 0.
- R2: A processor write to address 0 loads the outbound data register, which either side then reads at address 0. The same write sets status bit 0 (outbound-dirty).
- R3: An emulator write to address 1 loads the inbound data register, which either side then reads at address 1. The same write sets status bit 3 (inbound-dirty) and status bit 1 (inbound-event).
- R4: When debug mode is low, an emulator read of address 0 clears status bit 0 and sets status bit 2 (consumed-event). Under the same condition, a processor read of address 1 clears status bit 3.
- R5: When debug mode is high, no read from either side changes any status bit.
- R6: A processor write to address 2 clears status bit 1 or bit 2 wherever the written data has a 0 in that position. A 1 in that position has no effect. Status bits 0 and 3 are not affected by such a write.
- R7: When a set event and a clear event hit the same status flag in the same cycle, the flag ends up set.
- R8: A processor write to address 0 while bit 0 is already set overwrites the outbound data, and bit 0 stays set.
- R9: Status bits 31:4 always read as 0. The control register holds only bit 1 (inbound-event enable) and bit 2 (consumed-event enable); all its other bits read as 0.
- R10: The interrupt output is a register. In each cycle it shows whether, in the previous cycle, any status flag was set together with its matching control bit.
- R11: A port with its read enable low returns 0. Emulator writes to addresses 0, 2 and 3 have no effect. A processor write to address 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| dbg_mode | input | 1 | High: reads have no side effects on status |
| cpu_addr | input | 2 | Processor register address |
| cpu_we | input | 1 | Processor write enable |
| cpu_re | input | 1 | Processor read enable |
| cpu_wdata | input | 32 | Processor write data |
| cpu_rdata | output | 32 | Processor read data (combinational) |
| emu_addr | input | 2 | Emulator register address |
| emu_we | input | 1 | Emulator write enable |
| emu_re | input | 1 | Emulator read enable |
| emu_wdata | input | 32 | Emulator write data |
| emu_rdata | output | 32 | Emulator read data (combinational) |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions watch, on every cycle, the following properties:
- each data write raises its flags on the next cycle;
- no status bit falls in debug mode unless software clears it;
- writing 1 to an event flag leaves it set;
- the reserved and unused bits stay 0;
- the interrupt follows the enabled flags one cycle later.

Other properties need the bench's scenarios to show them. These are the outcomes when set and clear collide in the same cycle, data overwritten while still dirty, the values of returned data, and writes that must be ignored. A model of the whole register file, run over random traffic on both ports, covers these.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned MBX_ADDR_W = 2;
  localparam int unsigned MBX_FLAG_N = 4;

  typedef enum logic [MBX_ADDR_W-1:0] {
    MBX_REG_OUTB = 2'd0,
    MBX_REG_INB  = 2'd1,
    MBX_REG_STAT = 2'd2,
    MBX_REG_CTRL = 2'd3
  } mbx_reg_e;

  localparam int unsigned MBX_F_ODIRTY = 0;
  localparam int unsigned MBX_F_IEVT   = 1;
  localparam int unsigned MBX_F_CEVT   = 2;
  localparam int unsigned MBX_F_IDIRTY = 3;

  localparam logic [MBX_FLAG_N-1:0] MBX_EVT_MASK = 4'b0110;
endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] shift_d;
  logic [STAGES-1:0] shift_q;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end

  assign rst_sync_n = shift_q[STAGES-1];
endmodule

// File: rtl/mbx_word_reg.sv
module mbx_word_reg #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] q_d;

  always_comb begin
    q_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= q_d;
  end
endmodule

// File: rtl/mbx_flag_bank.sv
module mbx_flag_bank #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_q
);
  logic [N-1:0] flag_d;
  logic [N-1:0] flag_en;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_comb begin
      flag_en[i] = set_i[i] | clr_i[i];
      flag_d[i]  = set_i[i] | (flag_q[i] & ~clr_i[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q[i] <= 1'b0;
      else if (flag_en[i]) flag_q[i] <= flag_d[i];
    end
  end
endmodule

// File: rtl/mbx_irq_gen.sv
module mbx_irq_gen #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] flags,
  input  logic [N-1:0] enables,
  output logic         irq_q
);
  logic irq_d;

  always_comb begin
    irq_d = |(flags & enables);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end
endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox
  import mbx_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  dbg_mode,
  input  logic [MBX_ADDR_W-1:0] cpu_addr,
  input  logic                  cpu_we,
  input  logic                  cpu_re,
  input  logic [DATA_W-1:0]     cpu_wdata,
  output logic [DATA_W-1:0]     cpu_rdata,
  input  logic [MBX_ADDR_W-1:0] emu_addr,
  input  logic                  emu_we,
  input  logic                  emu_re,
  input  logic [DATA_W-1:0]     emu_wdata,
  output logic [DATA_W-1:0]     emu_rdata,
  output logic                  irq
);
  localparam int unsigned PAD_W = DATA_W - MBX_FLAG_N;

  logic                  rst_int_n;
  logic [DATA_W-1:0]     outb_q;
  logic [DATA_W-1:0]     inb_q;
  logic [MBX_FLAG_N-1:0] stat_q;
  logic [MBX_FLAG_N-1:0] ctrl_q;
  logic [MBX_FLAG_N-1:0] ctrl_din;
  logic [MBX_FLAG_N-1:0] flag_set;
  logic [MBX_FLAG_N-1:0] flag_clr;

  logic cpu_wr_outb, cpu_wr_stat, cpu_wr_ctrl, emu_wr_inb;
  logic emu_take_outb, cpu_take_inb;

  mbx_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  // access decode: only one side may write each register
  always_comb begin
    cpu_wr_outb   = cpu_we && (cpu_addr == MBX_REG_OUTB);
    cpu_wr_stat   = cpu_we && (cpu_addr == MBX_REG_STAT);
    cpu_wr_ctrl   = cpu_we && (cpu_addr == MBX_REG_CTRL);
    emu_wr_inb    = emu_we && (emu_addr == MBX_REG_INB);
    emu_take_outb = emu_re && (emu_addr == MBX_REG_OUTB) && !dbg_mode;
    cpu_take_inb  = cpu_re && (cpu_addr == MBX_REG_INB)  && !dbg_mode;
    ctrl_din      = cpu_wdata[MBX_FLAG_N-1:0] & MBX_EVT_MASK;
  end

  // flag events; the bank lets a set override a same-cycle clear
  always_comb begin
    flag_set = '0;
    flag_clr = '0;
    flag_set[MBX_F_ODIRTY] = cpu_wr_outb;
    flag_clr[MBX_F_ODIRTY] = emu_take_outb;
    flag_set[MBX_F_IDIRTY] = emu_wr_inb;
    flag_clr[MBX_F_IDIRTY] = cpu_take_inb;
    flag_set[MBX_F_IEVT]   = emu_wr_inb;
    flag_clr[MBX_F_IEVT]   = cpu_wr_stat && !cpu_wdata[MBX_F_IEVT];
    flag_set[MBX_F_CEVT]   = emu_take_outb;
    flag_clr[MBX_F_CEVT]   = cpu_wr_stat && !cpu_wdata[MBX_F_CEVT];
  end

  mbx_word_reg #(.WIDTH(DATA_W)) u_outb (
    .clk (clk), .rst_n (rst_int_n), .load (cpu_wr_outb), .din (cpu_wdata), .q (outb_q)
  );

  mbx_word_reg #(.WIDTH(DATA_W)) u_inb (
    .clk (clk), .rst_n (rst_int_n), .load (emu_wr_inb), .din (emu_wdata), .q (inb_q)
  );

  mbx_word_reg #(.WIDTH(MBX_FLAG_N)) u_ctrl (
    .clk (clk), .rst_n (rst_int_n), .load (cpu_wr_ctrl), .din (ctrl_din), .q (ctrl_q)
  );

  mbx_flag_bank #(.N(MBX_FLAG_N)) u_flags (
    .clk (clk), .rst_n (rst_int_n), .set_i (flag_set), .clr_i (flag_clr), .flag_q (stat_q)
  );

  mbx_irq_gen #(.N(MBX_FLAG_N)) u_irq (
    .clk (clk), .rst_n (rst_int_n), .flags (stat_q), .enables (ctrl_q), .irq_q (irq)
  );

  function automatic logic [DATA_W-1:0] read_sel(
    input logic                  re,
    input logic [MBX_ADDR_W-1:0] addr
  );
    logic [DATA_W-1:0] r;
    r = '0;
    if (re) begin
      case (mbx_reg_e'(addr))
        MBX_REG_OUTB: r = outb_q;
        MBX_REG_INB:  r = inb_q;
        MBX_REG_STAT: r = {{PAD_W{1'b0}}, stat_q};
        MBX_REG_CTRL: r = {{PAD_W{1'b0}}, ctrl_q};
        default:      r = '0;
      endcase
    end
    return r;
  endfunction

  always_comb begin
    cpu_rdata = read_sel(cpu_re, cpu_addr);
    emu_rdata = read_sel(emu_re, emu_addr);
  end
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker
  import mbx_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  dbg_mode,
  input logic [MBX_ADDR_W-1:0] cpu_addr,
  input logic                  cpu_we,
  input logic                  cpu_re,
  input logic [DATA_W-1:0]     cpu_wdata,
  input logic [DATA_W-1:0]     cpu_rdata,
  input logic [MBX_ADDR_W-1:0] emu_addr,
  input logic                  emu_we,
  input logic [MBX_FLAG_N-1:0] stat,
  input logic [MBX_FLAG_N-1:0] ctrl,
  input logic                  irq
);
  logic cpu_stat_wr;
  assign cpu_stat_wr = cpu_we && (cpu_addr == MBX_REG_STAT);

  AST_OUTB_WR_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_addr == MBX_REG_OUTB) |=> stat[MBX_F_ODIRTY]); // R2

  AST_INB_WR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (emu_we && emu_addr == MBX_REG_INB) |=> (stat[MBX_F_IDIRTY] && stat[MBX_F_IEVT])); // R3

  AST_DBG_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_mode && !cpu_stat_wr) |=> ((stat & $past(stat)) == $past(stat))); // R5

  AST_ONE_KEEPS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_stat_wr && cpu_wdata[MBX_F_IEVT] && stat[MBX_F_IEVT]) |=> stat[MBX_F_IEVT]); // R6

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_re && cpu_addr == MBX_REG_STAT) |-> (cpu_rdata[DATA_W-1:MBX_FLAG_N] == '0)); // R9

  AST_CTRL_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctrl & ~MBX_EVT_MASK) == '0)); // R9

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(stat & ctrl)))); // R10
endmodule

bind dbg_mailbox mbx_checker #(.DATA_W(DATA_W)) u_mbx_checker (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .dbg_mode  (dbg_mode),
  .cpu_addr  (cpu_addr),
  .cpu_we    (cpu_we),
  .cpu_re    (cpu_re),
  .cpu_wdata (cpu_wdata),
  .cpu_rdata (cpu_rdata),
  .emu_addr  (emu_addr),
  .emu_we    (emu_we),
  .stat      (stat_q),
  .ctrl      (ctrl_q),
  .irq       (irq)
);

// File: tb/dbg_mailbox_bench.sv
module dbg_mailbox_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, dbg_mode;
  logic [1:0]  cpu_addr, emu_addr;
  logic        cpu_we, cpu_re, emu_we, emu_re;
  logic [31:0] cpu_wdata, emu_wdata, cpu_rdata, emu_rdata;
  logic        irq;

  dbg_mailbox u_dbg_mailbox (
    .clk (clk), .rst_n (rst_n), .dbg_mode (dbg_mode),
    .cpu_addr (cpu_addr), .cpu_we (cpu_we), .cpu_re (cpu_re),
    .cpu_wdata (cpu_wdata), .cpu_rdata (cpu_rdata),
    .emu_addr (emu_addr), .emu_we (emu_we), .emu_re (emu_re),
    .emu_wdata (emu_wdata), .emu_rdata (emu_rdata), .irq (irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] m_outb = '0, m_inb = '0;
  logic [3:0]  m_stat = '0, m_ctrl = '0;
  logic        m_irq = 1'b0;
  logic [31:0] s_c, s_e;
  logic        s_irq;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mdl_read(input logic [1:0] a, input logic re);
    if (!re) return 32'h0;
    case (a)
      2'd0:    return m_outb;
      2'd1:    return m_inb;
      2'd2:    return {28'h0, m_stat};
      default: return {28'h0, m_ctrl};
    endcase
  endfunction

  function automatic string tag_of(input logic [1:0] a, input logic re);
    if (!re) return "R11";
    case (a)
      2'd0:    return "R2";
      2'd1:    return "R3";
      default: return "R9";
    endcase
  endfunction

  task automatic step(input logic [1:0] ca, input logic cwe, input logic cre, input logic [31:0] cwd,
                      input logic [1:0] ea, input logic ewe, input logic ere, input logic [31:0] ewd,
                      input logic dbg);
    logic [3:0] set_v, clr_v, nstat;
    logic [31:0] noutb, ninb;
    logic [3:0] nctrl;
    @(negedge clk);
    cpu_addr = ca; cpu_we = cwe; cpu_re = cre; cpu_wdata = cwd;
    emu_addr = ea; emu_we = ewe; emu_re = ere; emu_wdata = ewd;
    dbg_mode = dbg;
    #1;
    s_c = cpu_rdata; s_e = emu_rdata; s_irq = irq;
    chk(tag_of(ca, cre), cpu_rdata, mdl_read(ca, cre));
    chk(tag_of(ea, ere), emu_rdata, mdl_read(ea, ere));
    chk("R10", {31'h0, irq}, {31'h0, m_irq});
    set_v = '0; clr_v = '0;
    set_v[0] = cwe && ca == 2'd0;
    clr_v[0] = ere && ea == 2'd0 && !dbg;
    set_v[3] = ewe && ea == 2'd1;
    clr_v[3] = cre && ca == 2'd1 && !dbg;
    set_v[1] = set_v[3];
    set_v[2] = clr_v[0];
    clr_v[1] = cwe && ca == 2'd2 && !cwd[1];
    clr_v[2] = cwe && ca == 2'd2 && !cwd[2];
    nstat = set_v | (m_stat & ~clr_v);
    noutb = (cwe && ca == 2'd0) ? cwd : m_outb;
    ninb  = (ewe && ea == 2'd1) ? ewd : m_inb;
    nctrl = (cwe && ca == 2'd3) ? (cwd[3:0] & 4'b0110) : m_ctrl;
    @(posedge clk);
    m_irq = |(m_stat & m_ctrl);
    m_stat = nstat; m_outb = noutb; m_inb = ninb; m_ctrl = nctrl;
  endtask

  task automatic c_wr(input logic [1:0] a, input logic [31:0] d);
    step(a, 1'b1, 1'b0, d, 2'd0, 1'b0, 1'b0, 32'h0, 1'b0);
  endtask
  task automatic c_rd(input logic [1:0] a, input logic dbg);
    step(a, 1'b0, 1'b1, 32'h0, 2'd0, 1'b0, 1'b0, 32'h0, dbg);
  endtask
  task automatic e_wr(input logic [1:0] a, input logic [31:0] d);
    step(2'd0, 1'b0, 1'b0, 32'h0, a, 1'b1, 1'b0, d, 1'b0);
  endtask
  task automatic e_rd(input logic [1:0] a, input logic dbg);
    step(2'd0, 1'b0, 1'b0, 32'h0, a, 1'b0, 1'b1, 32'h0, dbg);
  endtask
  task automatic idle();
    step(2'd0, 1'b0, 1'b0, 32'h0, 2'd0, 1'b0, 1'b0, 32'h0, 1'b0);
  endtask
  task automatic stat_is(input string tag, input logic [31:0] exp);
    c_rd(2'd2, 1'b0);
    chk(tag, s_c, exp);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic dbg_r;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; dbg_mode = 1'b0;
    cpu_addr = 2'd2; cpu_we = 1'b0; cpu_re = 1'b1; cpu_wdata = '0;
    emu_addr = 2'd1; emu_we = 1'b0; emu_re = 1'b1; emu_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", cpu_rdata, 32'h0);
    chk("R1", emu_rdata, 32'h0);
    chk("R1", {31'h0, irq}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    for (int a = 0; a < 4; a++) begin
      c_rd(a[1:0], 1'b1);
      chk("R1", s_c, 32'h0);
    end

    c_wr(2'd0, 32'hA5A5_0001);       stat_is("R2", 32'h1);
    e_rd(2'd0, 1'b1);                chk("R2", s_e, 32'hA5A5_0001);
    stat_is("R5", 32'h1);
    c_wr(2'd0, 32'h0000_BEEF);       stat_is("R8", 32'h1);
    e_rd(2'd0, 1'b0);                chk("R8", s_e, 32'h0000_BEEF);
    stat_is("R4", 32'h4);
    e_wr(2'd1, 32'h1234_5678);       stat_is("R3", 32'hE);
    c_rd(2'd1, 1'b1);                chk("R3", s_c, 32'h1234_5678);
    stat_is("R5", 32'hE);
    c_rd(2'd1, 1'b0);                stat_is("R4", 32'h6);
    c_wr(2'd2, 32'hFFFF_FFFF);       stat_is("R6", 32'h6);
    c_wr(2'd2, 32'h0000_0002);       stat_is("R6", 32'h2);
    c_wr(2'd0, 32'h0000_C0DE);       stat_is("R6", 32'h3);
    c_wr(2'd2, 32'h0);               stat_is("R6", 32'h1);

    step(2'd2, 1'b1, 1'b0, 32'h0, 2'd1, 1'b1, 1'b0, 32'h7777_0000, 1'b0);
    stat_is("R7", 32'hB);
    step(2'd0, 1'b1, 1'b0, 32'h0000_C0DF, 2'd0, 1'b0, 1'b1, 32'h0, 1'b0);
    chk("R7", s_e, 32'h0000_C0DE);
    stat_is("R7", 32'hF);
    step(2'd1, 1'b0, 1'b1, 32'h0, 2'd1, 1'b1, 1'b0, 32'h7777_0001, 1'b0);
    stat_is("R7", 32'hF);

    e_wr(2'd0, 32'hDEAD_DEAD); e_wr(2'd2, 32'h0); e_wr(2'd3, 32'hFF);
    c_wr(2'd1, 32'h0000_0BAD);
    c_rd(2'd0, 1'b1);                chk("R11", s_c, 32'h0000_C0DF);
    e_rd(2'd1, 1'b0);                chk("R11", s_e, 32'h7777_0001);
    stat_is("R11", 32'hF);
    c_rd(2'd3, 1'b0);                chk("R11", s_c, 32'h0);
    idle();                          chk("R11", s_c, 32'h0);

    c_wr(2'd3, 32'hFFFF_FFFF);
    idle();                          chk("R10", {31'h0, s_irq}, 32'h0);
    c_rd(2'd3, 1'b0);                chk("R9", s_c, 32'h6);
    chk("R10", {31'h0, s_irq}, 32'h1);
    c_wr(2'd2, 32'h0);
    idle();                          chk("R10", {31'h0, s_irq}, 32'h1);
    idle();                          chk("R10", {31'h0, s_irq}, 32'h0);
    stat_is("R6", 32'h9);
    c_wr(2'd3, 32'h2);
    e_rd(2'd0, 1'b0);
    idle(); idle();                  chk("R10", {31'h0, s_irq}, 32'h0);
    stat_is("R4", 32'hC);
    c_wr(2'd3, 32'h4);
    idle(); idle();                  chk("R10", {31'h0, s_irq}, 32'h1);

    dbg_r = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 48 == 0) dbg_r = ~dbg_r;
      step(2'($urandom), ($urandom % 4) == 0, ($urandom % 2) == 1, $urandom,
           2'($urandom), ($urandom % 4) == 0, ($urandom % 2) == 1, $urandom, dbg_r);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule